// File: doc/BRIEF.md
# Per-Pixel Hit Timestamp Buffer

This block sits inside every pixel of a particle-tracking sensor. During a bunch train it watches the pixel's discriminator output. Each time a hit is seen, it saves the value of a bunch-crossing counter that is broadcast to all pixels, so the hit is tagged with the crossing it belongs to and no analog amplitude is kept. The store holds only a few entries. When every slot is full, later hits in the same train are dropped and a sticky overflow flag is raised.

Once the train ends, the pixel stops recording and becomes readable on a shared column bus. When the column controller selects the pixel, it presents its oldest unread timestamp together with a valid flag and the overflow flag. Each read strobe moves it on to the next entry. The next train start wipes the stored entries, the read position and the overflow flag, so each train begins clean.

The hit input is sampled once per clock. The broadcast counter stays at one value for a whole crossing, which may last several clocks. At most one entry is recorded per crossing, so a hit held high for several clocks of one crossing is stored once.

Top module: `pixstamp_pixel`

## Requirements
- R1: After the synchronous active-high reset, the buffer is empty and the overflow flag is clear. With the pixel selected and no train running, `data_valid`, `ts_out` and `overflow` all read 0.
- R2: While `train_active` is high, a clock edge with `hit` high stores the `bunch_cnt` value present at that edge as a TS_W-bit entry (default 14 bits).
- R3: While `train_active` is low, `hit` is ignored and the stored entries and entry count stay unchanged.
- R4: At most one entry is recorded per crossing. A hit whose `bunch_cnt` equals the crossing number of the most recently accepted hit in the same train is dropped.
- R5: The buffer holds DEPTH entries (default 4). An accepted hit that arrives while all slots are full is dropped and sets the overflow flag. The flag stays set until the next train start.
- R6: Readout works only while `train_active` is low. With `rd_sel` high and an unread entry left, `data_valid` is 1 and `ts_out` is the oldest unread entry (entries come out in arrival order). A clock edge with `rd_sel` and `rd_stb` both high in such a cycle advances to the next entry. Strobes during a train have no effect.
- R7: With `rd_sel` low, `data_valid`, `ts_out` and `overflow` are all 0 and `rd_stb` has no effect on the read position.
- R8: A train start is a cycle where `train_active` is high and was low in the previous cycle. A train start clears all entries, the read position and the overflow flag. A hit in that same cycle becomes the first entry of the new train.
- R9: `ts_out` is 0 whenever `data_valid` is 0, and `data_valid` stays 0 once every entry has been read. `overflow` reads the flag whenever the pixel is selected and no train is running, including after the buffer has been drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_active | input | 1 | High during a bunch train (acquisition window) |
| hit | input | 1 | Discriminator hit, sampled each clock |
| bunch_cnt | input | TS_W | Broadcast bunch-crossing number |
| rd_sel | input | 1 | Column readout selects this pixel |
| rd_stb | input | 1 | Read strobe: advance to the next entry |
| data_valid | output | 1 | An unread entry is presented |
| ts_out | output | TS_W | Oldest unread timestamp, 0 when not valid |
| overflow | output | 1 | Hits were lost in the last train |

## Verification
The embedded assertions check every cycle that the entry count never exceeds DEPTH and does not move outside a train. They also check that the overflow flag rises only on a full buffer and then stays set until a train start, and that a train start empties the buffer. Further cycle-by-cycle checks cover two things: two back-to-back writes never carry the same crossing number, and the read position never passes the entry count and never moves while the pixel is unselected. Only the bench scenarios can show that the stored values equal the counter values at the hit edges and that they come out oldest first. The bench scenarios also cover empty trains, exactly full trains and overflowing trains, checking each against a reference queue.

// File: rtl/pixstamp_pkg.sv
package pixstamp_pkg;

    localparam int DEF_TS_W  = 14;
    localparam int DEF_DEPTH = 4;

    // Window phase as seen by one pixel.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // between trains: readable
        PH_START = 2'd1,   // first cycle of a train
        PH_ACQ   = 2'd2    // remaining cycles of a train
    } phase_e;

    // Control bundle shared by the capture, store and readout pieces.
    typedef struct packed {
        logic start;
        logic acq;
        logic readable;
    } ctl_t;

    function automatic phase_e classify(input logic act, input logic act_q);
        if (act && !act_q) return PH_START;
        if (act)           return PH_ACQ;
        return PH_IDLE;
    endfunction

    function automatic ctl_t decode_phase(input phase_e ph);
        ctl_t c;
        c.start    = (ph == PH_START);
        c.acq      = (ph != PH_IDLE);
        c.readable = (ph == PH_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/pixstamp_capture.sv
module pixstamp_capture
    import pixstamp_pkg::*;
#(
    parameter int TS_W = DEF_TS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            train_active,
    input  logic            hit,
    input  logic [TS_W-1:0] bunch_cnt,
    input  logic            full,
    output ctl_t            ctl,
    output logic            wr_en,
    output logic [TS_W-1:0] wr_data,
    output logic            ovf_set
);

    logic            act_q;
    logic [TS_W-1:0] last_bc;
    logic            last_ok;
    logic            dup;
    logic            accept;
    logic            full_eff;
    phase_e          ph;

    always_comb begin
        ph       = classify(train_active, act_q);
        ctl      = decode_phase(ph);
        dup      = last_ok && !ctl.start && (bunch_cnt == last_bc);
        accept   = ctl.acq && hit && !dup;
        // A train start empties the store in the same edge, so it is never full then.
        full_eff = full && !ctl.start;
        wr_en    = accept && !full_eff;
        ovf_set  = accept && full_eff;
        wr_data  = bunch_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            last_ok <= 1'b0;
            last_bc <= '0;
        end else begin
            act_q <= train_active;
            if (accept) begin
                last_ok <= 1'b1;
                last_bc <= bunch_cnt;
            end else if (ctl.start) begin
                last_ok <= 1'b0;
            end
        end
    end

    // R4: two writes in a row within a train never carry the same crossing
    p_one_per_crossing_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && !$past(rst) && !ctl.start) |-> (bunch_cnt != $past(bunch_cnt)));

    // R3: nothing is accepted outside a train
    p_idle_no_capture_r3: assert property (@(posedge clk) disable iff (rst)
        !train_active |-> (!wr_en && !ovf_set));

endmodule

// File: rtl/pixstamp_store.sv
module pixstamp_store
    import pixstamp_pkg::*;
#(
    parameter int TS_W  = DEF_TS_W,
    parameter int DEPTH = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wr_en,
    input  logic [TS_W-1:0]  wr_data,
    input  logic             ovf_set,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             ovf,
    output logic [TS_W-1:0]  slots [DEPTH]
);

    logic [CNT_W-1:0] wr_idx;

    assign wr_idx = start ? '0 : count;
    assign full   = (count == CNT_W'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == CNT_W'(g))) begin
                slots[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (start) begin
            count <= wr_en ? CNT_W'(1) : '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_en)   count <= count + CNT_W'(1);
            if (ovf_set) ovf   <= 1'b1;
        end
    end

    // R5: never more entries than slots
    p_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R5: overflow only appears with every slot in use
    p_ovf_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> full);

    // R5: overflow is sticky until a train start
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !start) |=> ovf);

endmodule

// File: rtl/pixstamp_readout.sv
module pixstamp_readout
    import pixstamp_pkg::*;
#(
    parameter int TS_W  = DEF_TS_W,
    parameter int DEPTH = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             readable,
    input  logic             rd_sel,
    input  logic             rd_stb,
    input  logic [CNT_W-1:0] count,
    input  logic             ovf,
    input  logic [TS_W-1:0]  slots [DEPTH],
    output logic             data_valid,
    output logic [TS_W-1:0]  ts_out,
    output logic             overflow
);

    logic [CNT_W-1:0] rd_ptr;
    logic [TS_W-1:0]  picked;
    logic             avail;
    logic             adv;

    assign avail = readable && (rd_ptr < count);
    assign adv   = rd_sel && rd_stb && avail;

    always_comb begin
        picked = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == CNT_W'(i)) picked = slots[i];
        end
    end

    assign data_valid = rd_sel && avail;
    assign ts_out     = data_valid ? picked : '0;
    assign overflow   = rd_sel && readable && ovf;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            rd_ptr <= '0;
        end else if (adv) begin
            rd_ptr <= rd_ptr + CNT_W'(1);
        end
    end

    // R6: the read position never passes the stored count
    p_ptr_within_count_r6: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= count);

    // R7: an unselected pixel keeps its read position
    p_unselected_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_sel && !start) |=> $stable(rd_ptr));

    // R6: a strobe on a valid entry moves to the next one
    p_strobe_steps_r6: assert property (@(posedge clk) disable iff (rst)
        (data_valid && rd_stb) |=> (rd_ptr == $past(rd_ptr) + CNT_W'(1)));

endmodule

// File: rtl/pixstamp_pixel.sv
module pixstamp_pixel
    import pixstamp_pkg::*;
#(
    parameter int TS_W  = DEF_TS_W,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            train_active,
    input  logic            hit,
    input  logic [TS_W-1:0] bunch_cnt,
    input  logic            rd_sel,
    input  logic            rd_stb,
    output logic            data_valid,
    output logic [TS_W-1:0] ts_out,
    output logic            overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    ctl_t             ctl;
    logic             wr_en;
    logic [TS_W-1:0]  wr_data;
    logic             ovf_set;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             ovf;
    logic [TS_W-1:0]  slots [DEPTH];

    pixstamp_capture #(.TS_W(TS_W)) u_capture (
        .clk          (clk),
        .rst          (rst),
        .train_active (train_active),
        .hit          (hit),
        .bunch_cnt    (bunch_cnt),
        .full         (full),
        .ctl          (ctl),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ovf_set      (ovf_set)
    );

    pixstamp_store #(.TS_W(TS_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .start   (ctl.start),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ovf_set (ovf_set),
        .count   (count),
        .full    (full),
        .ovf     (ovf),
        .slots   (slots)
    );

    pixstamp_readout #(.TS_W(TS_W), .DEPTH(DEPTH)) u_readout (
        .clk        (clk),
        .rst        (rst),
        .start      (ctl.start),
        .readable   (ctl.readable),
        .rd_sel     (rd_sel),
        .rd_stb     (rd_stb),
        .count      (count),
        .ovf        (ovf),
        .slots      (slots),
        .data_valid (data_valid),
        .ts_out     (ts_out),
        .overflow   (overflow)
    );

    // R3: the entry count does not move outside a train
    p_count_frozen_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !train_active |=> $stable(count));

    // R8: a train start leaves at most the hit of that cycle and no overflow
    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ctl.start |=> ((count <= CNT_W'(1)) && !ovf));

endmodule

// File: tb/pixstamp_pixel_tb.sv
module pixstamp_pixel_tb;

    localparam int TS_W  = 14;
    localparam int DEPTH = 4;
    localparam int NVEC  = 25;
    localparam int NTRAIN = 32;

    typedef struct packed {
        logic            tr;
        logic            hit;
        logic [TS_W-1:0] bc;
        logic            sel;
        logic            stb;
        logic            ev;
        logic [TS_W-1:0] ets;
        logic            eov;
        logic [3:0]      req;
    } vec_t;

    // Inputs of one cycle, then outputs expected in that same cycle.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd1}, // R1 empty
        '{1'b1, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd8}, // R8 start
        '{1'b1, 1'b1, 14'd5, 1'b1, 1'b1, 1'b0, 14'd0, 1'b0, 4'd2}, // R2 store 5
        '{1'b1, 1'b1, 14'd5, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd4}, // R4 duplicate
        '{1'b1, 1'b1, 14'd6, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd2}, // R2 store 6
        '{1'b1, 1'b0, 14'd7, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd6}, // R6 no read in train
        '{1'b0, 1'b1, 14'd9, 1'b1, 1'b0, 1'b1, 14'd5, 1'b0, 4'd3}, // R3 hit ignored
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 1'b1, 14'd5, 1'b0, 4'd6}, // R6 read 5
        '{1'b0, 1'b0, 14'd0, 1'b0, 1'b1, 1'b0, 14'd0, 1'b0, 4'd7}, // R7 unselected
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 1'b1, 14'd6, 1'b0, 4'd7}, // R7 undisturbed
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 1'b1, 14'd6, 1'b0, 4'd6}, // R6 read 6
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd9}, // R9 drained
        '{1'b1, 1'b1, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd8}, // R8 start+hit
        '{1'b1, 1'b1, 14'd1, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd2},
        '{1'b1, 1'b1, 14'd2, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd2},
        '{1'b1, 1'b1, 14'd3, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd5}, // R5 now full
        '{1'b1, 1'b1, 14'd4, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd5}, // R5 overflow
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 1'b1, 14'd0, 1'b1, 4'd5},
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 1'b1, 14'd1, 1'b1, 4'd6},
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 1'b1, 14'd2, 1'b1, 4'd6},
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b1, 1'b1, 14'd3, 1'b1, 4'd6},
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b1, 4'd9}, // R9 flag kept
        '{1'b0, 1'b0, 14'd0, 1'b0, 1'b0, 1'b0, 14'd0, 1'b0, 4'd7}, // R7 gated
        '{1'b1, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd8}, // R8 clear
        '{1'b0, 1'b0, 14'd0, 1'b1, 1'b0, 1'b0, 14'd0, 1'b0, 4'd8}  // R8 empty train
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            train_active = 1'b0;
    logic            hit = 1'b0;
    logic [TS_W-1:0] bunch_cnt = '0;
    logic            rd_sel = 1'b0;
    logic            rd_stb = 1'b0;
    logic            data_valid;
    logic [TS_W-1:0] ts_out;
    logic            overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pixstamp_pixel #(.TS_W(TS_W), .DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .train_active (train_active),
        .hit          (hit),
        .bunch_cnt    (bunch_cnt),
        .rd_sel       (rd_sel),
        .rd_stb       (rd_stb),
        .data_valid   (data_valid),
        .ts_out       (ts_out),
        .overflow     (overflow)
    );

    task automatic apply(input logic tr, input logic h, input logic [TS_W-1:0] bc,
                         input logic sel, input logic stb);
        @(negedge clk);
        train_active = tr;
        hit          = h;
        bunch_cnt    = bc;
        rd_sel       = sel;
        rd_stb       = stb;
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference queue state for the random trains.
    int   refq [$];
    int   last_bc;
    bit   have_last;
    bit   ref_ovf;

    task automatic model_step(input bit start, input bit h, input int bc);
        if (start) begin
            refq.delete();
            have_last = 1'b0;
            ref_ovf   = 1'b0;
        end
        if (h && !(have_last && bc == last_bc)) begin
            have_last = 1'b1;
            last_bc   = bc;
            if (refq.size() < DEPTH) refq.push_back(bc);
            else ref_ovf = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        apply(1'b1, 1'b1, 14'd3, 1'b1, 1'b1);
        apply(1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
        apply(1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        apply(1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
        chk("R1 valid after reset", int'(data_valid), 0);
        chk("R1 ts after reset", int'(ts_out), 0);
        chk("R1 overflow after reset", int'(overflow), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].tr, VECS[i].hit, VECS[i].bc, VECS[i].sel, VECS[i].stb);
            chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), int'(data_valid), int'(VECS[i].ev));
            chk($sformatf("R%0d vec%0d ts", VECS[i].req, i), int'(ts_out), int'(VECS[i].ets));
            chk($sformatf("R%0d vec%0d ovf", VECS[i].req, i), int'(overflow), int'(VECS[i].eov));
        end

        // Random trains against the reference queue: R2 R4 R5 R6 R9
        for (int t = 0; t < NTRAIN; t++) begin
            int mode;
            mode = t % 4;
            for (int c = 0; c < 40; c++) begin
                bit h;
                int bc;
                bc = c / 2;
                case (mode)
                    0: h = 1'b0;                               // empty train
                    1: h = (c % 2 == 0) && (c < 2 * DEPTH);    // exactly full
                    2: h = (c % 2 == 0) && (c < 2 * DEPTH + 2);// one over
                    default: h = ($urandom % 5) == 0;
                endcase
                apply(1'b1, h, TS_W'(bc), 1'b1, 1'($urandom % 2));
                model_step(c == 0, h, bc);
                chk($sformatf("R6 train%0d no read in train", t), int'(data_valid), 0);
            end
            apply(1'b0, 1'b0, 14'd0, 1'b0, 1'b1);
            chk($sformatf("R7 train%0d unselected valid", t), int'(data_valid), 0);
            chk($sformatf("R7 train%0d unselected ovf", t), int'(overflow), 0);
            for (int k = 0; k <= DEPTH; k++) begin
                bit ev;
                ev = (k < refq.size());
                apply(1'b0, 1'($urandom % 2), TS_W'($urandom), 1'b1, 1'b1);
                chk($sformatf("R6 train%0d entry%0d valid", t, k), int'(data_valid), int'(ev));
                chk($sformatf("R2 train%0d entry%0d ts", t, k), int'(ts_out), ev ? refq[k] : 0);
                chk($sformatf("R5 train%0d entry%0d ovf", t, k), int'(overflow), int'(ref_ovf));
            end
            apply(1'b0, 1'b0, 14'd0, 1'b1, 1'b0);
            chk($sformatf("R9 train%0d drained", t), int'(data_valid), 0);
            chk($sformatf("R9 train%0d ovf kept", t), int'(overflow), int'(ref_ovf));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule